// File: doc/BRIEF.md
# Memory-Mapped Switch and LED Decoder

This block sits between the memory port of a small 8-bit processor and its 256-location address space. The two most significant address bits split that space into four quarters of 64 locations. Addresses 0x00 to 0xBF reach ordinary synchronous RAM. Addresses 0xC0 to 0xFF form a single I/O window.

A read from the I/O window returns the state of four switches. A write to the I/O window loads the written byte into an LED output register. The RAM never sees that write.

The RAM answers a read one clock after the address is presented. For that reason, the decoder registers the region of each address and uses it on the following cycle to choose the read data. The switch inputs pass through two flip-flops before they reach the read path.

Top module: `io_region_decoder`

## Requirements
- R1: When the address registered at the last clock edge lies in 0x00–0xBF (bits [7:6] = 00, 01 or 10), `cpu_rdata` equals `ram_rdata`.
- R2: When the address registered at the last clock edge lies in 0xC0–0xFF (bits [7:6] = 11), `cpu_rdata[3:0]` shows the synchronized switches and `cpu_rdata[7:4]` reads 0.
- R3: For addresses 0x00–0xBF, `ram_we` follows `cpu_we` in the same cycle.
- R4: For addresses 0xC0–0xFF, `ram_we` stays 0 whatever `cpu_we` is.
- R5: At a clock edge where `cpu_we` is 1 and the address lies in 0xC0–0xFF, `led_out` takes the value of `cpu_wdata`.
- R6: `led_out` keeps its value across RAM-region writes and across any read.
- R7: While `rst_n` is low, `led_out` clears to 0 and the registered region returns to RAM.
- R8: A switch change reaches `cpu_rdata` on the second clock edge after it is applied, not on the first.
- R9: Between clock edges, a new address does not change which source `cpu_rdata` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write enable |
| cpu_rdata | output | 8 | Read data returned to the processor |
| ram_we | output | 1 | Gated write enable to RAM |
| ram_rdata | input | 8 | Synchronous RAM read data |
| sw_in | input | 4 | Raw switch levels |
| led_out | output | 8 | LED register |

## Verification
The hardest case to reach is a switch change that races the two-stage synchronizer during consecutive I/O reads. The stimulus changes the switches in the same cycle as an I/O read, then reads the window again. The first read must still return the old level and the second the new one.

A second hard case is an address that changes between edges without moving the read source. The bench presents a RAM address right after an I/O read and samples the read data before the next edge.

// File: rtl/io_region_decoder.sv
module io_region_decoder #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SW_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              ram_we,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [SW_W-1:0]   sw_in,
  output logic [DATA_W-1:0] led_out
);
  localparam logic [1:0] IO_QUARTER = 2'b11;
  localparam int         PAD_W      = DATA_W - SW_W;

  logic            io_hit;
  logic            io_hit_q;
  logic [SW_W-1:0] sw_meta, sw_sync;

  assign io_hit = (cpu_addr[ADDR_W-1 -: 2] == IO_QUARTER);
  assign ram_we = cpu_we & ~io_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_hit_q <= 1'b0;
      sw_meta  <= '0;
      sw_sync  <= '0;
      led_out  <= '0;
    end else begin
      io_hit_q <= io_hit;
      sw_meta  <= sw_in;
      sw_sync  <= sw_meta;
      if (cpu_we && io_hit) led_out <= cpu_wdata;
    end
  end

  assign cpu_rdata = io_hit_q ? {{PAD_W{1'b0}}, sw_sync} : ram_rdata;

  p_ram_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: 2] != IO_QUARTER) |=> (cpu_rdata == ram_rdata));

  p_io_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: 2] == IO_QUARTER) |=> (cpu_rdata[DATA_W-1:SW_W] == '0));

  p_led_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[ADDR_W-1 -: 2] == IO_QUARTER) |=> (led_out == $past(cpu_wdata)));

  p_led_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr[ADDR_W-1 -: 2] == IO_QUARTER) |=> $stable(led_out));
endmodule

// File: tb/io_region_decoder_tb_top.sv
module io_region_decoder_tb_top;
  typedef struct {
    logic [7:0] rdata;
    logic [7:0] led;
    logic       we;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0, ram_rdata = '0;
  logic       cpu_we = 1'b0;
  logic [3:0] sw_in = '0;
  logic [7:0] cpu_rdata, led_out;
  logic       ram_we;
  int         vectors = 0, misses = 0;
  exp_t       sb[$];

  always #5 clk = ~clk;

  io_region_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .sw_in(sw_in), .led_out(led_out)
  );

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] a, logic w, logic [7:0] wd, logic [3:0] sw,
                       logic [7:0] rd, logic [7:0] e_rd, logic [7:0] e_led,
                       logic e_we, string req);
    exp_t e;
    @(negedge clk);
    cpu_addr = a; cpu_we = w; cpu_wdata = wd; sw_in = sw; ram_rdata = rd;
    e.rdata = e_rd; e.led = e_led; e.we = e_we; e.req = req;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check8(e.req, "cpu_rdata", cpu_rdata, e.rdata);
      check8(e.req, "led_out", led_out, e.led);
      check8(e.req, "ram_we", {7'd0, ram_we}, {7'd0, e.we});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check8("R7", "led_out in reset", led_out, 8'h00);
    rst_n = 1'b1;
    apply(8'h00, 1'b0, 8'h00, 4'h0, 8'h3C, 8'h3C, 8'h00, 1'b0, "R7");
    apply(8'h40, 1'b1, 8'h11, 4'h0, 8'h5A, 8'h5A, 8'h00, 1'b1, "R3");
    apply(8'hBF, 1'b1, 8'h22, 4'h0, 8'h77, 8'h77, 8'h00, 1'b1, "R1");
    apply(8'hC0, 1'b1, 8'h9C, 4'h0, 8'h66, 8'h00, 8'h9C, 1'b0, "R4");
    apply(8'hFF, 1'b0, 8'hEE, 4'h0, 8'h55, 8'h00, 8'h9C, 1'b0, "R6");
    apply(8'h80, 1'b1, 8'h33, 4'h0, 8'h44, 8'h44, 8'h9C, 1'b1, "R6");
    apply(8'hC5, 1'b0, 8'h00, 4'hA, 8'h12, 8'h00, 8'h9C, 1'b0, "R8");
    apply(8'hC5, 1'b0, 8'h00, 4'hA, 8'h12, 8'h0A, 8'h9C, 1'b0, "R8");
    apply(8'h3F, 1'b0, 8'h00, 4'hA, 8'h99, 8'h99, 8'h9C, 1'b0, "R1");
    #1 check8("R9", "cpu_rdata before edge", cpu_rdata, 8'h0A);
    apply(8'hC0, 1'b1, 8'h5F, 4'h3, 8'h00, 8'h0A, 8'h5F, 1'b0, "R5");
    apply(8'hFE, 1'b0, 8'h00, 4'h3, 8'hF0, 8'h03, 8'h5F, 1'b0, "R2");
    apply(8'h7F, 1'b1, 8'h01, 4'h3, 8'h21, 8'h21, 8'h5F, 1'b1, "R3");
    apply(8'hBF, 1'b0, 8'h00, 4'h3, 8'h00, 8'h00, 8'h5F, 1'b0, "R3");
    apply(8'hE0, 1'b0, 8'h00, 4'h3, 8'hC3, 8'h03, 8'h5F, 1'b0, "R2");
    wait (sb.size() == 0);
    @(negedge clk);
    rst_n = 1'b0; cpu_we = 1'b0;
    @(negedge clk);
    check8("R7", "led_out after reset", led_out, 8'h00);
    ram_rdata = 8'hB7;
    #1 check8("R7", "region after reset", cpu_rdata, 8'hB7);
    rst_n = 1'b1;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule